// File: doc/BRIEF.md
# Biphase-Mark Audio Line Transmitter

This block takes a stereo serial audio stream made of a bit clock, a word-select (frame sync) line and a data line. It turns that stream into a self-clocking biphase-mark line of the kind used for consumer digital audio links. The serial framing can be left-justified, I2S or right-justified, and the sample width can be 16, 18, 20 or 24 bits. A fast local clock samples the three serial inputs. Each completed sample is placed at the top of a 24-bit audio field and packed into a 32-slot subframe. The subframe carries a preamble, the audio, validity, user, channel-status and parity slots. The subframe is then sent as biphase-mark half-slots, one half-slot per bit-clock edge.

The output rate is tied to the input: each half-frame of 32 bit clocks produces one 64-half-slot subframe, so subframes follow each other without gaps. Left and right subframes alternate. Each left subframe opens a new frame, and frames are counted over a block of 192. The first left subframe of a block carries a distinct preamble. The channel-status bit of every frame is taken from a 192-bit word that software holds on an input port.

Top module: `spdif_tx`

## Requirements
- R1: After reset the line is low. It stays constant until the first word-select change has been seen and a full sample has been taken in.
- R2: Format code 0 is left-justified: the MSB is on the first bit clock of a half-frame and word-select high means left. Code 1 is I2S: the MSB comes one bit clock after the word-select change and word-select low means left. Code 2 is right-justified: the LSB is on the last of the 32 bit clocks of a half-frame and word-select high means left. Code 3 behaves like code 0. Data and word-select are sampled on the rising bit-clock edge, and bits outside the sample window are ignored.
- R3: Width codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. The sample is placed MSB-aligned in the 24-bit audio field, and the unused low bits are zero.
- R4: A subframe has 32 slots: preamble in slots 0 to 3, audio LSB-first in slots 4 to 27, validity (always 0) in slot 28, user (always 0) in slot 29, channel status in slot 30 and parity in slot 31.
- R5: The parity slot makes slots 4 to 31 hold an even number of ones.
- R6: Each bit-clock edge gives one half-slot. Every slot from 4 on begins with a line transition, and a second transition mid-slot encodes a 1.
- R7: The preamble half-slot patterns are B = 11101000, M = 11100010 and W = 11100100 when the line was low before the preamble. They are inverted when the line was high before it.
- R8: A frame is one left subframe followed by one right subframe. Right subframes use W. The left subframe of frame 0 uses B and other left subframes use M. The frame number counts left subframes from 0 after reset and wraps after 191.
- R9: The channel-status slot of both subframes of frame f equals bit f of the channel-status word.
- R10: A subframe's first half-slot is driven on the first bit-clock edge after the last bit of its sample, and the next subframe follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, at least ten times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bclk | input | 1 | Serial bit clock |
| ser_fs | input | 1 | Word-select / frame sync |
| ser_sd | input | 1 | Serial audio data |
| cfg_fmt | input | 2 | Framing code (R2) |
| cfg_width | input | 2 | Sample width code (R3) |
| cs_bits | input | 192 | Channel-status word, bit f used in frame f |
| bmc_out | output | 1 | Biphase-mark encoded line |

## Verification
Each bit-clock edge reaches the line three encoder-clock edges later: two synchronizer stages and then the encoder register. The bench therefore samples the line one nanosecond before the next bit-clock edge, which gives one recorded value per half-slot. The first subframe's preamble must begin at the recorded half-slot that follows the bit-clock edge just after the sample's last bit. The bench checks that exact index, derived from format and width, for R10. All later subframes are decoded at fixed 64-half-slot steps, so any gap or slip shows up as a wrong preamble or a broken transition.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

   typedef enum logic [1:0] {
      FMT_LEFT  = 2'd0,
      FMT_I2S   = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_LEFT2 = 2'd3
   } ser_fmt_e;

   localparam int unsigned AUDIO_W   = 24;
   localparam int unsigned SF_SLOTS  = 32;
   localparam int unsigned SF_HALVES = 2 * SF_SLOTS;
   localparam int unsigned PRE_HALVES = 8;

   // preamble half-slot patterns, MSB sent first, for a low line before them
   localparam logic [7:0] PAT_BLOCK = 8'b1110_1000;
   localparam logic [7:0] PAT_LEFT  = 8'b1110_0010;
   localparam logic [7:0] PAT_RIGHT = 8'b1110_0100;

   function automatic int unsigned width_of(logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/spdif_in_sync.sv
module spdif_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic bclk_i,
   input  logic fs_i,
   input  logic sd_i,
   output logic fs_o,
   output logic sd_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("spdif_in_sync needs at least two stages");
   end

   logic [STAGES-1:0][2:0] pipe_q;
   logic                   bclk_last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pipe_q      <= '0;
         bclk_last_q <= 1'b0;
      end else begin
         pipe_q      <= {pipe_q[STAGES-2:0], {bclk_i, fs_i, sd_i}};
         bclk_last_q <= pipe_q[LAST][2];
      end
   end

   assign fs_o   = pipe_q[LAST][1];
   assign sd_o   = pipe_q[LAST][0];
   assign rise_o = pipe_q[LAST][2] & ~bclk_last_q;
   assign fall_o = ~pipe_q[LAST][2] & bclk_last_q;

endmodule

// File: rtl/spdif_deser.sv
module spdif_deser
   import spdif_tx_pkg::*;
#(
   parameter int HALF_BCLKS = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rise_i,
   input  logic               fs_i,
   input  logic               sd_i,
   input  logic [1:0]         fmt_i,
   input  logic [1:0]         wid_i,
   output logic               valid_o,
   output logic [AUDIO_W-1:0] data_o,
   output logic               left_o,
   output logic               locked_o
);

   localparam int CNT_W = $clog2(HALF_BCLKS) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0]   cnt_q, cnt_cur, n_bits, first_bit, last_bit;
   logic               fs_q, locked_q, fs_edge, in_win;
   logic [AUDIO_W-1:0] sh_q, sh_nx;

   always_comb begin
      n_bits = CNT_W'(width_of(wid_i));
      case (ser_fmt_e'(fmt_i))
         FMT_I2S:   first_bit = CNT_W'(1);
         FMT_RIGHT: first_bit = CNT_W'(HALF_BCLKS) - n_bits;
         default:   first_bit = '0;
      endcase
      last_bit = first_bit + n_bits - CNT_W'(1);
      fs_edge  = fs_i != fs_q;
      if (fs_edge)
         cnt_cur = '0;
      else if (cnt_q == CNT_MAX)
         cnt_cur = cnt_q;
      else
         cnt_cur = cnt_q + CNT_W'(1);
      in_win = (locked_q || fs_edge) && cnt_cur >= first_bit && cnt_cur <= last_bit;
      sh_nx  = {sh_q[AUDIO_W-2:0], sd_i};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         fs_q     <= 1'b0;
         locked_q <= 1'b0;
         sh_q     <= '0;
         valid_o  <= 1'b0;
         data_o   <= '0;
         left_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (rise_i) begin
            fs_q  <= fs_i;
            cnt_q <= cnt_cur;
            if (fs_edge)
               locked_q <= 1'b1;
            if (in_win)
               sh_q <= sh_nx;
            if (in_win && cnt_cur == last_bit) begin
               valid_o <= 1'b1;
               data_o  <= sh_nx << (CNT_W'(AUDIO_W) - n_bits);
               left_o  <= (ser_fmt_e'(fmt_i) == FMT_I2S) ? ~fs_i : fs_i;
            end
         end
      end
   end

   assign locked_o = locked_q;

endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
   import spdif_tx_pkg::*;
#(
   parameter int BLOCK_FRAMES = 192,
   parameter int FR_W         = $clog2(BLOCK_FRAMES)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick_i,
   input  logic                    valid_i,
   input  logic [AUDIO_W-1:0]      data_i,
   input  logic                    left_i,
   input  logic [BLOCK_FRAMES-1:0] cs_i,
   output logic                    line_o,
   output logic [FR_W-1:0]         frame_o
);

   localparam logic [5:0]      HS_LAST = 6'(SF_HALVES - 1);
   localparam logic [5:0]      HS_PRE  = 6'(PRE_HALVES);
   localparam logic [FR_W-1:0] FR_LAST = FR_W'(BLOCK_FRAMES - 1);

   logic               pend_q, pend_left_q;
   logic [AUDIO_W-1:0] pend_data_q;
   logic               act_q, line_q, base_q, seen_left_q;
   logic [5:0]         hs_q, nh;
   logic [31:0]        slots_q, slots_nx;
   logic [7:0]         pre_q, pre_nx;
   logic [FR_W-1:0]    frame_q, frame_nx, start_frame;
   logic               cs_bit, lvl_nx;

   always_comb begin
      if (!seen_left_q)
         frame_nx = '0;
      else if (frame_q == FR_LAST)
         frame_nx = '0;
      else
         frame_nx = frame_q + FR_W'(1);
      start_frame = pend_left_q ? frame_nx : frame_q;
      cs_bit      = cs_i[start_frame];
      // parity, channel status, user 0, validity 0, audio, preamble placeholder
      slots_nx    = {^{cs_bit, pend_data_q}, cs_bit, 1'b0, 1'b0, pend_data_q, 4'b0000};
      if (!pend_left_q)
         pre_nx = PAT_RIGHT;
      else if (start_frame == '0)
         pre_nx = PAT_BLOCK;
      else
         pre_nx = PAT_LEFT;
      nh = hs_q + 6'd1;
      if (nh < HS_PRE)
         lvl_nx = pre_q[3'd7 - nh[2:0]] ^ base_q;
      else if (!nh[0])
         lvl_nx = ~line_q;
      else
         lvl_nx = line_q ^ slots_q[nh[5:1]];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q      <= 1'b0;
         pend_left_q <= 1'b0;
         pend_data_q <= '0;
         act_q       <= 1'b0;
         hs_q        <= '0;
         line_q      <= 1'b0;
         base_q      <= 1'b0;
         slots_q     <= '0;
         pre_q       <= '0;
         frame_q     <= '0;
         seen_left_q <= 1'b0;
      end else begin
         if (tick_i) begin
            if (act_q && hs_q != HS_LAST) begin
               hs_q   <= nh;
               line_q <= lvl_nx;
            end else if (pend_q) begin
               act_q   <= 1'b1;
               hs_q    <= '0;
               base_q  <= line_q;
               line_q  <= pre_nx[7] ^ line_q;
               slots_q <= slots_nx;
               pre_q   <= pre_nx;
               pend_q  <= 1'b0;
               if (pend_left_q) begin
                  frame_q     <= frame_nx;
                  seen_left_q <= 1'b1;
               end
            end else begin
               act_q <= 1'b0;
            end
         end
         if (valid_i) begin
            pend_q      <= 1'b1;
            pend_data_q <= data_i;
            pend_left_q <= left_i;
         end
      end
   end

   assign line_o  = line_q;
   assign frame_o = frame_q;

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
   import spdif_tx_pkg::*;
#(
   parameter int HALF_BCLKS   = 32,
   parameter int BLOCK_FRAMES = 192,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ser_bclk,
   input  logic                    ser_fs,
   input  logic                    ser_sd,
   input  logic [1:0]              cfg_fmt,
   input  logic [1:0]              cfg_width,
   input  logic [BLOCK_FRAMES-1:0] cs_bits,
   output logic                    bmc_out
);

   localparam int FR_W = $clog2(BLOCK_FRAMES);

   if (HALF_BCLKS < int'(AUDIO_W) + 1) begin : g_bad_half
      $error("HALF_BCLKS must leave room for a 24-bit I2S word");
   end
   if (HALF_BCLKS != int'(SF_SLOTS)) begin : g_bad_rate
      $error("one half-frame must span one subframe of 32 slots");
   end
   if (BLOCK_FRAMES < 2) begin : g_bad_block
      $error("BLOCK_FRAMES must be at least 2");
   end

   logic               fs_s, sd_s, b_rise, b_fall, half_tick;
   logic               smp_valid, smp_left, in_locked;
   logic [AUDIO_W-1:0] smp_data;
   logic [FR_W-1:0]    frame_idx;

   spdif_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .bclk_i (ser_bclk),
      .fs_i   (ser_fs),
      .sd_i   (ser_sd),
      .fs_o   (fs_s),
      .sd_o   (sd_s),
      .rise_o (b_rise),
      .fall_o (b_fall)
   );

   assign half_tick = b_rise | b_fall;

   spdif_deser #(.HALF_BCLKS(HALF_BCLKS)) u_deser (
      .clk      (clk),
      .rst      (rst),
      .rise_i   (b_rise),
      .fs_i     (fs_s),
      .sd_i     (sd_s),
      .fmt_i    (cfg_fmt),
      .wid_i    (cfg_width),
      .valid_o  (smp_valid),
      .data_o   (smp_data),
      .left_o   (smp_left),
      .locked_o (in_locked)
   );

   spdif_bmc_enc #(.BLOCK_FRAMES(BLOCK_FRAMES), .FR_W(FR_W)) u_enc (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (half_tick),
      .valid_i (smp_valid),
      .data_i  (smp_data),
      .left_i  (smp_left),
      .cs_i    (cs_bits),
      .line_o  (bmc_out),
      .frame_o (frame_idx)
   );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
   parameter int BLOCK_FRAMES = 192,
   parameter int FR_W         = $clog2(BLOCK_FRAMES)
) (
   input logic            clk,
   input logic            rst,
   input logic            bmc_out,
   input logic            half_tick,
   input logic            smp_valid,
   input logic [23:0]     smp_data,
   input logic [1:0]      cfg_width,
   input logic [FR_W-1:0] frame_idx,
   input logic            in_locked
);

   logic [23:0] low_mask;

   always_comb begin
      case (cfg_width)
         2'd0:    low_mask = 24'h0000FF;
         2'd1:    low_mask = 24'h00003F;
         2'd2:    low_mask = 24'h00000F;
         default: low_mask = 24'h000000;
      endcase
   end

   // R6: the line only moves in response to a bit-clock edge
   p_line_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
      (bmc_out != $past(bmc_out)) |-> $past(half_tick));

   // R2: a completed sample is announced for exactly one cycle
   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      smp_valid |=> !smp_valid);

   // R3: the deserialiser hands over MSB-aligned samples
   p_msb_aligned_r3: assert property (@(posedge clk) disable iff (rst)
      smp_valid |-> ((smp_data & low_mask) == 24'h0));

   // R8: the frame number stays inside the block
   p_frame_range_r8: assert property (@(posedge clk) disable iff (rst)
      half_tick |-> (frame_idx < FR_W'(BLOCK_FRAMES)));

   // R1: nothing is driven before the input framing is found
   p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (rst)
      !in_locked |-> !bmc_out);

endmodule

bind spdif_tx spdif_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bmc_out   (bmc_out),
   .half_tick (half_tick),
   .smp_valid (smp_valid),
   .smp_data  (smp_data),
   .cfg_width (cfg_width),
   .frame_idx (frame_idx),
   .in_locked (in_locked)
);

// File: tb/spdif_tx_tb_top.sv
module spdif_tx_tb_top;

   localparam int CLK_NS  = 10;
   localparam int HALF_NS = 50;
   localparam int BLOCK   = 192;
   localparam int REC_MAX = 26000;
   localparam int SF_MAX  = 420;
   localparam int WATCHDOG_CYC = 195000;
   localparam int NVEC = 6;
   // {format code, width code, left base, right base}
   localparam logic [51:0] VECS [NVEC] = '{
      {2'd0, 2'd3, 24'hA5C3E1, 24'h1E2D3C},
      {2'd1, 2'd0, 24'h00BEEF, 24'h00F00D},
      {2'd2, 2'd1, 24'h02ACE1, 24'h013579},
      {2'd2, 2'd2, 24'h0F0F0F, 24'h0ABCDE},
      {2'd3, 2'd2, 24'h0C0FFE, 24'h07A5A5},
      {2'd1, 2'd3, 24'h800001, 24'h7FFFFE}
   };

   logic clk = 1'b0, rst = 1'b1;
   logic ser_bclk = 1'b0, ser_fs = 1'b0, ser_sd = 1'b0;
   logic [1:0] cfg_fmt = 2'd0, cfg_width = 2'd0;
   logic [BLOCK-1:0] cs_bits;
   logic bmc_out;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   bit hrec [REC_MAX];
   int nrec;
   logic [1:0]  sf_pre  [SF_MAX];
   logic [31:0] sf_bits [SF_MAX];
   bit          sf_bp   [SF_MAX];
   int          sf_pos  [SF_MAX];
   int nsf;

   spdif_tx dut_i (
      .clk       (clk),
      .rst       (rst),
      .ser_bclk  (ser_bclk),
      .ser_fs    (ser_fs),
      .ser_sd    (ser_sd),
      .cfg_fmt   (cfg_fmt),
      .cfg_width (cfg_width),
      .cs_bits   (cs_bits),
      .bmc_out   (bmc_out)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int wid_of(logic [1:0] c);
      case (c) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
   endfunction

   function automatic logic [23:0] smp_of(logic [23:0] base, int f);
      return base ^ 24'(f * 24'h0F1E2D);
   endfunction

   // sd pattern for one half-frame; bits outside the window are driven high
   function automatic logic [31:0] half_word(logic [1:0] fmt, int n, logic [23:0] v);
      logic [31:0] w;
      w = '1;
      for (int c = 0; c < 32; c++) begin
         if ((fmt == 2'd0 || fmt == 2'd3) && c < n) w[31-c] = v[n-1-c];
         if (fmt == 2'd1 && c >= 1 && c <= n)       w[31-c] = v[n-c];
         if (fmt == 2'd2 && c >= 32 - n)            w[31-c] = v[31-c];
      end
      return w;
   endfunction

   task automatic bclk_cycle(logic fs_v, logic sd_v);
      ser_fs = fs_v;
      ser_sd = sd_v;
      #(HALF_NS-1);
      if (nrec < REC_MAX) hrec[nrec] = bmc_out;
      nrec++;
      #1 ser_bclk = 1'b1;
      #(HALF_NS-1);
      if (nrec < REC_MAX) hrec[nrec] = bmc_out;
      nrec++;
      #1 ser_bclk = 1'b0;
   endtask

   task automatic drive_half(logic fs_v, logic [31:0] w);
      for (int k = 0; k < 32; k++) bclk_cycle(fs_v, w[31-k]);
   endtask

   task automatic do_reset();
      rst = 1'b1; ser_bclk = 1'b0; ser_fs = 1'b0; ser_sd = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(posedge clk);
      #(CLK_NS/2);
      nrec = 0;
   endtask

   task automatic decode();
      int i;
      nsf = 0;
      i = 1;
      while (i + 2 < nrec && !(hrec[i-1] != hrec[i] && hrec[i] == hrec[i+1] && hrec[i] == hrec[i+2]))
         i++;
      while (i + 64 <= nrec && i + 64 <= REC_MAX && nsf < SF_MAX) begin
         logic [7:0]  p;
         logic [31:0] b;
         bit          ok, base;
         base = hrec[i-1];
         for (int k = 0; k < 8; k++) p[7-k] = hrec[i+k] ^ base;
         b = '0;
         ok = 1'b1;
         for (int s = 4; s < 32; s++) begin
            b[s] = hrec[i+2*s] != hrec[i+2*s+1];
            if (hrec[i+2*s] == hrec[i+2*s-1]) ok = 1'b0;
         end
         sf_pre[nsf]  = (p == 8'hE8) ? 2'd0 : (p == 8'hE2) ? 2'd1 : (p == 8'hE4) ? 2'd2 : 2'd3;
         sf_bits[nsf] = b;
         sf_bp[nsf]   = ok;
         sf_pos[nsf]  = i;
         nsf++;
         i += 64;
      end
   endtask

   task automatic run_stream(logic [1:0] fmt, logic [1:0] wc, logic [23:0] lb, logic [23:0] rb, int nfr);
      int  n;
      logic lfs;
      do_reset();
      cfg_fmt = fmt;
      cfg_width = wc;
      n = wid_of(wc);
      lfs = (fmt == 2'd1) ? 1'b0 : 1'b1;
      drive_half(~lfs, half_word(fmt, n, 24'h0));
      for (int f = 0; f < nfr; f++) begin
         drive_half(lfs,  half_word(fmt, n, smp_of(lb, f)));
         drive_half(~lfs, half_word(fmt, n, smp_of(rb, f)));
      end
      drive_half(lfs,  half_word(fmt, n, 24'h0));
      drive_half(~lfs, half_word(fmt, n, 24'h0));
      decode();
   endtask

   function automatic int first_block();
      for (int k = 0; k < nsf; k++) if (sf_pre[k] == 2'd0) return k;
      return -1;
   endfunction

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYC);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < BLOCK; i++) cs_bits[i] = 1'(((i * 13) + (i / 7)) >> 1);

      // R1: reset state and no output while word-select never changes
      do_reset();
      check(bmc_out == 1'b0, "R1", "line after reset", longint'(bmc_out), 0);
      begin
         int moves;
         moves = 0;
         for (int k = 0; k < 40; k++) bclk_cycle(1'b0, 1'(k));
         for (int k = 1; k < nrec; k++) if (hrec[k] != 1'b0) moves++;
         check(moves == 0, "R1", "line activity before framing", moves, 0);
      end

      // table of framings and widths: R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0]  fmt, wc;
         logic [23:0] lb, rb, ea, aa;
         int n, k0, last, epos, bad_pre, bad_aud, bad_vuc, bad_pb;
         logic [1:0] epre;
         {fmt, wc, lb, rb} = VECS[v];
         n = wid_of(wc);
         run_stream(fmt, wc, lb, rb, 3);
         k0 = first_block();
         bad_pre = 0; bad_aud = 0; bad_vuc = 0; bad_pb = 0;
         aa = '0; ea = '0;
         if (k0 < 0 || k0 + 6 > nsf) begin
            bad_pre = 99; bad_aud = 99; bad_vuc = 99; bad_pb = 99;
         end else begin
            for (int j = 0; j < 6; j++) begin
               logic [31:0] b;
               b = sf_bits[k0+j];
               epre = (j % 2 == 1) ? 2'd2 : (j == 0) ? 2'd0 : 2'd1;
               if (sf_pre[k0+j] != epre) bad_pre++;
               ea = 24'(smp_of((j % 2 == 0) ? lb : rb, j / 2) << (24 - n));
               if (b[27:4] != ea) begin bad_aud++; aa = b[27:4]; end
               if (b[28] != 1'b0 || b[29] != 1'b0 || b[30] != cs_bits[j/2]) bad_vuc++;
               if ((^b[31:4]) != 1'b0 || !sf_bp[k0+j]) bad_pb++;
            end
         end
         check(bad_pre == 0, "R7 R8", $sformatf("vector %0d preamble order", v), bad_pre, 0);
         check(bad_aud == 0, "R2 R3", $sformatf("vector %0d audio field", v), aa, ea);
         check(bad_vuc == 0, "R4 R9", $sformatf("vector %0d V/U/C slots", v), bad_vuc, 0);
         check(bad_pb == 0, "R5 R6", $sformatf("vector %0d parity and transitions", v), bad_pb, 0);
         last = (fmt == 2'd1) ? n : (fmt == 2'd2) ? 31 : n - 1;
         epos = 64 + 2 * last + 2;
         check(k0 >= 0 && sf_pos[(k0 < 0) ? 0 : k0] == epos, "R10",
               $sformatf("vector %0d first block preamble half-slot", v),
               (k0 < 0) ? -1 : sf_pos[k0], epos);
      end

      // R8 R9: a full block plus one frame wraps back to preamble B
      begin
         int k0, bad_pre, bad_cs, nb;
         logic [1:0] epre;
         run_stream(2'd0, 2'd3, 24'h123456, 24'h654321, BLOCK + 1);
         k0 = first_block();
         bad_pre = 0; bad_cs = 0; nb = 0;
         if (k0 < 0 || k0 + 2 * (BLOCK + 1) > nsf) begin
            bad_pre = 999; bad_cs = 999;
         end else begin
            for (int j = 0; j < 2 * (BLOCK + 1); j++) begin
               int f;
               f = (j / 2) % BLOCK;
               epre = (j % 2 == 1) ? 2'd2 : (f == 0) ? 2'd0 : 2'd1;
               if (sf_pre[k0+j] != epre) bad_pre++;
               if (sf_pre[k0+j] == 2'd0) nb++;
               if (sf_bits[k0+j][30] != cs_bits[f]) bad_cs++;
            end
         end
         check(bad_pre == 0, "R8", "preambles across block wrap", bad_pre, 0);
         check(nb == 2, "R8", "count of block preambles in 193 frames", nb, 2);
         check(bad_cs == 0, "R9", "channel status across block", bad_cs, 0);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule